// File: doc/BRIEF.md
# Fast-Ethernet Link Integrity Qualifier

This block decides when a 10/100 receiver may report a usable link. At 100 Mb/s it watches a descrambler lock flag and a one-per-clock idle-symbol flag: link is granted only after lock has held without a break for a qualification interval. Once granted, link is kept as long as a run of consecutive idle symbols completes inside every monitoring window. Short noise bursts that break a run are therefore absorbed, and the link drops only when a whole window passes without one complete run.

At 10 Mb/s it takes a link-test-pass candidate from the receive integrity logic. The candidate first waits in an extend state. It is promoted to link only once transmit enable and receive data valid are low together, so link never comes up in the middle of a frame. A candidate raised briefly by 100BASE-TX idle waveforms falls away as soon as it drops, so it never turns into a lasting 10 Mb/s link. All intervals are parameters in clock cycles, which lets a bench shrink them.

The controller has five states:
- `LQ_DOWN` (no link).
- `LQ_QUAL100` (lock being timed).
- `LQ_UP100` (100 Mb/s link, idle windows being monitored).
- `LQ_EXT10` (10 Mb/s candidate waiting for quiet).
- `LQ_UP10` (10 Mb/s link).

Its transitions are:
- DOWN to QUAL100 when 100 Mb/s is selected and the descrambler is locked. It goes straight to UP100 when `QUAL_CYCLES` is 1.
- DOWN to EXT10 when 10 Mb/s is selected and the candidate is high.
- QUAL100 to UP100 on the last qualifying lock cycle.
- QUAL100 to DOWN when lock is lost or the speed selection changes.
- UP100 to DOWN when a window expires or the speed selection changes.
- EXT10 to UP10 when transmit and receive are both idle.
- EXT10 to DOWN and UP10 to DOWN when the candidate drops or 100 Mb/s is selected.
- Any state to DOWN on synchronous reset.

Top module: `link_integrity_qual`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) forces `link_up` and `link_speed` low after that edge, from any state, and clears every counter.
- R2: With `speed_sel`=1 (1 selects 100 Mb/s), `link_up` and `link_speed` rise after the `QUAL_CYCLES`-th consecutive clock edge at which `descr_locked` is sampled high, and not after the edge before it.
- R3: A single edge with `descr_locked` low during qualification returns the block to no-link, and a fresh run of `QUAL_CYCLES` locked edges is then needed.
- R4: While linked at 100 Mb/s, `IDLE_RUN` consecutive edges with `sym_idle` high complete a run and restart the monitoring window, so link survives beyond the first window.
- R5: While linked at 100 Mb/s, if no run completes, `link_up` falls after the `WIN_CYCLES`-th edge counted from the start of the window and is still high after the edge before it.
- R6: An edge with `sym_idle` low resets the idle run, so runs of `IDLE_RUN`-1 idles separated by non-idle symbols never restart the window.
- R7: With `speed_sel`=0 and `lt_cand` high, the block sits in the extend state with `link_up` low while `tx_en` or `rx_dv` is high. `link_up` rises after the first edge in that state at which both are low, and `link_speed` stays 0.
- R8: `lt_cand` sampled low in the extend state or in the 10 Mb/s link state returns the block to no-link after that edge.
- R9: A change of `speed_sel` away from the speed of the current link or qualification drops `link_up` after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol clock, one symbol per cycle |
| rst | input | 1 | Synchronous reset, active high |
| speed_sel | input | 1 | 1 selects 100 Mb/s rules, 0 selects 10 Mb/s rules |
| descr_locked | input | 1 | Descrambler lock indication |
| sym_idle | input | 1 | Current received symbol is idle |
| lt_cand | input | 1 | 10 Mb/s link-test-pass candidate |
| tx_en | input | 1 | Transmit enable from the MAC side |
| rx_dv | input | 1 | Receive data valid toward the MAC side |
| link_up | output | 1 | Qualified link status |
| link_speed | output | 1 | 1 while linked at 100 Mb/s, else 0 |

## Verification
Both outputs decode the state register directly, so a stimulus applied before an edge shows its effect just after that edge. The bench drives inputs 1 ns after a rising edge and compares outputs 1 ns after a later one. Qualification is checked at exactly `QUAL_CYCLES`-1 and `QUAL_CYCLES` edges after lock is first sampled. Window expiry is checked at `WIN_CYCLES`-1 and `WIN_CYCLES` edges after the window start, which is either entry into link or the edge that completed the last idle run. Each 10 Mb/s vector is applied for one edge and checked right after it.

// File: rtl/lq_pkg.sv
package lq_pkg;

    typedef enum logic [2:0] {
        LQ_DOWN    = 3'd0,
        LQ_QUAL100 = 3'd1,
        LQ_UP100   = 3'd2,
        LQ_EXT10   = 3'd3,
        LQ_UP10    = 3'd4
    } lq_state_e;

endpackage

// File: rtl/lq_qual_timer.sv
// Counts consecutive enabled cycles; done marks the last one of the interval.
module lq_qual_timer #(
    parameter int QUAL_CYCLES = 6_250_000
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic done
);
    localparam int QW = $clog2(QUAL_CYCLES + 1);
    localparam logic [QW-1:0] Q_LAST = QW'(QUAL_CYCLES - 1);

    logic [QW-1:0] cnt;

    assign done = en && (cnt == Q_LAST);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt <= '0;
        end else if (done) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/lq_idle_monitor.sv
// Tracks the current idle run and the window since the last completed run.
module lq_idle_monitor #(
    parameter int WIN_CYCLES = 250_000,
    parameter int IDLE_RUN   = 12
) (
    input  logic clk,
    input  logic rst,
    input  logic active,
    input  logic sym_idle,
    output logic run_done,
    output logic win_expired
);
    localparam int RW = $clog2(IDLE_RUN + 1);
    localparam int WW = $clog2(WIN_CYCLES + 1);
    localparam logic [RW-1:0] RUN_LAST = RW'(IDLE_RUN - 1);
    localparam logic [WW-1:0] WIN_LAST = WW'(WIN_CYCLES - 1);

    logic [RW-1:0] run_cnt;
    logic [WW-1:0] win_cnt;

    assign run_done    = active && sym_idle && (run_cnt == RUN_LAST);
    assign win_expired = active && !run_done && (win_cnt == WIN_LAST);

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            run_cnt <= '0;
        end else if (!sym_idle || run_done) begin
            run_cnt <= '0;
        end else begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            win_cnt <= '0;
        end else if (run_done || win_expired) begin
            win_cnt <= '0;
        end else begin
            win_cnt <= win_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/link_integrity_qual.sv
module link_integrity_qual #(
    parameter int QUAL_CYCLES = 6_250_000,
    parameter int WIN_CYCLES  = 250_000,
    parameter int IDLE_RUN    = 12
) (
    input  logic clk,
    input  logic rst,
    input  logic speed_sel,
    input  logic descr_locked,
    input  logic sym_idle,
    input  logic lt_cand,
    input  logic tx_en,
    input  logic rx_dv,
    output logic link_up,
    output logic link_speed
);
    import lq_pkg::*;

    lq_state_e state;
    lq_state_e state_nx;

    logic qual_en;
    logic qual_done;
    logic mon_active;
    logic run_done;
    logic win_expired;
    logic lock100;
    logic quiet10;

    assign lock100    = speed_sel && descr_locked;
    assign quiet10    = !tx_en && !rx_dv;
    assign qual_en    = lock100 && ((state == LQ_DOWN) || (state == LQ_QUAL100));
    assign mon_active = (state == LQ_UP100);

    lq_qual_timer #(
        .QUAL_CYCLES(QUAL_CYCLES)
    ) u_qual (
        .clk (clk),
        .rst (rst),
        .en  (qual_en),
        .done(qual_done)
    );

    lq_idle_monitor #(
        .WIN_CYCLES(WIN_CYCLES),
        .IDLE_RUN  (IDLE_RUN)
    ) u_mon (
        .clk        (clk),
        .rst        (rst),
        .active     (mon_active),
        .sym_idle   (sym_idle),
        .run_done   (run_done),
        .win_expired(win_expired)
    );

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            LQ_DOWN: begin
                if (lock100) begin
                    state_nx = qual_done ? LQ_UP100 : LQ_QUAL100;
                end else if (!speed_sel && lt_cand) begin
                    state_nx = LQ_EXT10;
                end
            end
            LQ_QUAL100: begin
                if (!lock100) begin
                    state_nx = LQ_DOWN;
                end else if (qual_done) begin
                    state_nx = LQ_UP100;
                end
            end
            LQ_UP100: begin
                if (!speed_sel || win_expired) begin
                    state_nx = LQ_DOWN;
                end
            end
            LQ_EXT10: begin
                if (speed_sel || !lt_cand) begin
                    state_nx = LQ_DOWN;
                end else if (quiet10) begin
                    state_nx = LQ_UP10;
                end
            end
            LQ_UP10: begin
                if (speed_sel || !lt_cand) begin
                    state_nx = LQ_DOWN;
                end
            end
            default: state_nx = LQ_DOWN;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= LQ_DOWN;
        end else begin
            state <= state_nx;
        end
    end

    // Outputs
    always_comb begin
        link_up    = 1'b0;
        link_speed = 1'b0;
        unique case (state)
            LQ_UP100: begin
                link_up    = 1'b1;
                link_speed = 1'b1;
            end
            LQ_UP10: begin
                link_up    = 1'b1;
            end
            default: begin
                link_up    = 1'b0;
                link_speed = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/lq_checker.sv
module lq_checker (
    input logic              clk,
    input logic              rst,
    input logic              speed_sel,
    input logic              descr_locked,
    input logic              lt_cand,
    input logic              tx_en,
    input logic              rx_dv,
    input logic              link_up,
    input logic              link_speed,
    input lq_pkg::lq_state_e state
);
    import lq_pkg::*;

    p_reset_clears_r1: assert property (@(posedge clk)
        rst |=> (!link_up && !link_speed));

    p_speed_needs_link_r2: assert property (@(posedge clk) disable iff (rst)
        link_speed |-> link_up);

    p_rise100_locked_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(link_speed) |-> $past(descr_locked && speed_sel));

    p_lock_loss_restart_r3: assert property (@(posedge clk) disable iff (rst)
        (state == LQ_QUAL100 && !descr_locked) |=> (state == LQ_DOWN));

    p_ten_needs_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        ($rose(link_up) && !link_speed) |-> $past(lt_cand && !tx_en && !rx_dv && !speed_sel));

    p_cand_drop_r8: assert property (@(posedge clk) disable iff (rst)
        (link_up && !link_speed && !lt_cand) |=> !link_up);

    p_speed_change_r9: assert property (@(posedge clk) disable iff (rst)
        (link_speed && !speed_sel) |=> !link_up);
endmodule

bind link_integrity_qual lq_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .speed_sel   (speed_sel),
    .descr_locked(descr_locked),
    .lt_cand     (lt_cand),
    .tx_en       (tx_en),
    .rx_dv       (rx_dv),
    .link_up     (link_up),
    .link_speed  (link_speed),
    .state       (state)
);

// File: tb/link_integrity_qual_test.sv
`timescale 1ns/1ps
module link_integrity_qual_test;
    localparam int QUAL = 20;
    localparam int WIN  = 40;
    localparam int RUN  = 12;

    // {req[3:0], speed_sel, lt_cand, tx_en, rx_dv, exp_link_up, exp_link_speed}
    localparam int NV = 14;
    localparam logic [9:0] VEC [NV] = '{
        10'b0111_0_1_1_0_0_0,  // R7 candidate, tx busy: extend
        10'b0111_0_1_1_0_0_0,  // R7 still busy
        10'b0111_0_1_0_1_0_0,  // R7 rx busy
        10'b0111_0_1_0_0_1_0,  // R7 both quiet: link
        10'b0111_0_1_1_1_1_0,  // R7 traffic after link keeps link
        10'b1000_0_0_0_0_0_0,  // R8 candidate drops from link
        10'b0111_0_1_0_0_0_0,  // R7 quiet already, one edge in extend
        10'b0111_0_1_0_0_1_0,  // R7 link
        10'b1001_1_1_0_0_0_0,  // R9 speed change drops 10M link
        10'b0111_0_1_1_0_0_0,  // R7 extend again
        10'b1000_0_0_1_0_0_0,  // R8 candidate drops in extend
        10'b0111_0_1_0_0_0_0,  // R7 extend
        10'b0111_0_1_0_0_1_0,  // R7 link
        10'b1000_0_0_0_0_0_0   // R8 drop
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic speed_sel = 1'b0;
    logic descr_locked = 1'b0;
    logic sym_idle = 1'b0;
    logic lt_cand = 1'b0;
    logic tx_en = 1'b0;
    logic rx_dv = 1'b0;
    logic link_up;
    logic link_speed;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    link_integrity_qual #(
        .QUAL_CYCLES(QUAL),
        .WIN_CYCLES (WIN),
        .IDLE_RUN   (RUN)
    ) uut (
        .clk         (clk),
        .rst         (rst),
        .speed_sel   (speed_sel),
        .descr_locked(descr_locked),
        .sym_idle    (sym_idle),
        .lt_cand     (lt_cand),
        .tx_en       (tx_en),
        .rx_dv       (rx_dv),
        .link_up     (link_up),
        .link_speed  (link_speed)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic ticks(input int n);
        repeat (n) tick();
    endtask

    task automatic chk(input logic act, input logic exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        speed_sel = 1'b0;
        descr_locked = 1'b0;
        sym_idle = 1'b0;
        lt_cand = 1'b0;
        tx_en = 1'b0;
        rx_dv = 1'b0;
        tick();
        rst = 1'b0;
    endtask

    task automatic bring_up100(input string tag);
        do_reset();
        speed_sel = 1'b1;
        descr_locked = 1'b1;
        ticks(QUAL);
        chk(link_up, 1'b1, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL R1 watchdog: actual hung expected finished");
        report();
        $finish;
    end

    initial begin
        // R1 reset state
        ticks(2);
        do_reset();
        chk(link_up, 1'b0, "R1 link_up after reset");
        chk(link_speed, 1'b0, "R1 link_speed after reset");

        // Table: 10 Mb/s extend, link and drop sequences (R7 R8 R9)
        for (int i = 0; i < NV; i++) begin
            speed_sel = VEC[i][5];
            lt_cand   = VEC[i][4];
            tx_en     = VEC[i][3];
            rx_dv     = VEC[i][2];
            tick();
            chk(link_up, VEC[i][1],
                $sformatf("R%0d vector %0d link_up", int'(VEC[i][9:6]), i));
            chk(link_speed, VEC[i][0],
                $sformatf("R%0d vector %0d link_speed", int'(VEC[i][9:6]), i));
        end

        // R2 qualification timing
        do_reset();
        speed_sel = 1'b1;
        descr_locked = 1'b1;
        ticks(QUAL - 1);
        chk(link_up, 1'b0, "R2 one edge before qualification");
        tick();
        chk(link_up, 1'b1, "R2 link_up at qualification");
        chk(link_speed, 1'b1, "R2 link_speed at qualification");

        // R3 lock loss restarts qualification
        do_reset();
        speed_sel = 1'b1;
        descr_locked = 1'b1;
        ticks(QUAL - 2);
        descr_locked = 1'b0;
        tick();
        chk(link_up, 1'b0, "R3 after lock loss");
        descr_locked = 1'b1;
        ticks(QUAL - 1);
        chk(link_up, 1'b0, "R3 restarted count not done");
        tick();
        chk(link_up, 1'b1, "R3 restarted count done");

        // R5 window expiry with no idle runs
        ticks(WIN - 1);
        chk(link_up, 1'b1, "R5 one edge before window end");
        tick();
        chk(link_up, 1'b0, "R5 window expired");
        descr_locked = 1'b0;

        // R4 completed idle run restarts window
        bring_up100("R4 bring up");
        ticks(10);
        sym_idle = 1'b1;
        ticks(RUN);
        sym_idle = 1'b0;
        chk(link_up, 1'b1, "R4 after idle run");
        ticks(WIN - 1);
        chk(link_up, 1'b1, "R4 window restarted by run");
        tick();
        chk(link_up, 1'b0, "R4 restarted window expired");

        // R6 broken runs do not restart window
        bring_up100("R6 bring up");
        for (int k = 0; k < 2; k++) begin
            sym_idle = 1'b1;
            ticks(RUN - 1);
            sym_idle = 1'b0;
            tick();
        end
        ticks(WIN - 1 - 2 * RUN);
        chk(link_up, 1'b1, "R6 before window end");
        tick();
        chk(link_up, 1'b0, "R6 broken runs ignored");

        // R9 speed change drops 100 Mb/s link
        bring_up100("R9 bring up");
        speed_sel = 1'b0;
        tick();
        chk(link_up, 1'b0, "R9 speed change at 100");
        chk(link_speed, 1'b0, "R9 speed flag at 100");

        // R1 reset while linked
        bring_up100("R1 bring up");
        rst = 1'b1;
        tick();
        chk(link_up, 1'b0, "R1 reset while linked");
        chk(link_speed, 1'b0, "R1 reset speed while linked");
        rst = 1'b0;
        descr_locked = 1'b0;
        tick();

        report();
        $finish;
    end
endmodule